// File: doc/BRIEF.md
# Self-Draining Sine/Cosine Phase Converter

This block turns a stream of phase words into complex unit samples. Each phase word is an unsigned fraction of a full turn. For each one the block returns the sine and the cosine of that angle. Inside it is a fixed-latency lookup pipeline, and that pipeline only moves forward when a new word is pushed into its head. Without help, the last few results of a burst would stay inside it until more input arrived.

The wrapper tracks how many real samples are still inside the pipeline. When the upstream side stops sending while real samples remain, the wrapper pushes filler words into the pipeline. Each word carries a one-bit tag that says whether it is real or filler. Results tagged as filler are dropped at the tail. Real results, together with their end-of-burst flag, go into a small output buffer that honours backpressure. The pipeline does not advance while that buffer is full, so no result is overwritten.

A three-state controller drives the pipeline. In IDLE nothing real is in flight. FILL means real samples are in flight and the last cycle took upstream input. DRAIN means real samples are in flight and filler words are being injected. The state goes to IDLE whenever the next in-flight count is zero. Otherwise it goes to FILL when the input is valid and to DRAIN when the input is idle. Reset is widened inside the block so that it always lasts at least two cycles.

Top module: `phase_drain_wrap`

## Requirements
- R1: The phase input is an unsigned 24-bit fraction of one turn. The output `m_data[31:16]` carries the sine and `m_data[15:0]` carries the cosine, both in two's complement with 14 fractional bits (16384 means 1.0). Results are exact at every multiple of 1/8 turn and within 8 LSB everywhere else.
- R2: Every accepted phase produces exactly one output word, and the words come out in the order the phases were accepted.
- R3: The last flag given with a phase comes out on `m_last` with the result of that same phase, and it is never dropped.
- R4: Once `s_valid` goes low, every accepted phase reaches the output without any further input. A single phase accepted while `m_ready` is high shows up on `m_valid` within LAT+4 cycles.
- R5: Filler results never reach the output. After the block has drained, `m_valid` stays low.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays unchanged.
- R7: `s_ready` and `m_valid` are low while `rst` is high. `s_ready` also stays low for one more cycle after `rst` falls, so a one-cycle reset pulse blocks input for two cycles.
- R8: With `m_ready` held low and the input valid on every cycle, exactly BUF_DEPTH+LAT phases (6 with the default parameters) are accepted before `s_ready` stays low. All of them come out once `m_ready` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_phase | input | PHASE_W | Phase word, unsigned fraction of a turn |
| s_last | input | 1 | End-of-burst flag for this phase |
| s_valid | input | 1 | Phase word valid |
| s_ready | output | 1 | Block can accept a phase word |
| m_data | output | 32 | Sine in upper half, cosine in lower half |
| m_last | output | 1 | End-of-burst flag for this result |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Downstream accepts the result |

## Verification
Phases at every eighth of a turn are fed back to back with the output always ready, which pins the exact value mapping and the word ordering. A single phase followed by silence exercises self-draining: if filler injection is missing, that result never appears. A continuous input against a stalled output counts how many words the block can absorb, which tells a correct stall gate apart from one that overwrites or loses results. Long random runs with gaps on both handshakes, random last flags and a final idle period show whether any end-of-burst flag is lost, whether any filler word leaks out, and whether anything stays stuck inside the pipeline.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
    localparam int TRIG_W = 16;

    typedef enum logic [1:0] {
        DR_IDLE,
        DR_FILL,
        DR_DRAIN
    } drain_state_t;
endpackage

// File: rtl/pdw_sincos_pipe.sv
module pdw_sincos_pipe
    import pdw_pkg::*;
#(
    parameter int PHASE_W = 24,
    parameter int LAT     = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv,
    input  logic [PHASE_W-1:0]    in_phase,
    input  logic                  in_last,
    input  logic                  in_real,
    output logic                  out_fire,
    output logic                  out_real,
    output logic                  out_last,
    output logic [2*TRIG_W-1:0]   out_word
);
    localparam int     FRAC_W = PHASE_W - 7;
    localparam longint QTR    = longint'(1) << (PHASE_W - 2);

    // Quarter-wave sine samples at k/32 of a quarter turn, scaled by 2^14.
    function automatic longint quarter_tab(input int k);
        case (k)
            0: return 0;       1: return 804;     2: return 1606;    3: return 2404;
            4: return 3196;    5: return 3981;    6: return 4756;    7: return 5520;
            8: return 6270;    9: return 7005;    10: return 7723;   11: return 8423;
            12: return 9102;   13: return 9760;   14: return 10394;  15: return 11003;
            16: return 11585;  17: return 12140;  18: return 12665;  19: return 13160;
            20: return 13623;  21: return 14053;  22: return 14449;  23: return 14811;
            24: return 15137;  25: return 15426;  26: return 15679;  27: return 15893;
            28: return 16069;  29: return 16207;  30: return 16305;  31: return 16364;
            default: return 16384;
        endcase
    endfunction

    function automatic logic [TRIG_W-1:0] sin_turn(input logic [PHASE_W-1:0] p);
        longint x, a, fr, lo, hi, mag;
        int k;
        logic [TRIG_W-1:0] r;
        x   = longint'(p[PHASE_W-3:0]);
        a   = p[PHASE_W-2] ? (QTR - x) : x;
        k   = int'(a >> FRAC_W);
        fr  = a & ((longint'(1) << FRAC_W) - 1);
        lo  = quarter_tab(k);
        hi  = (k >= 32) ? lo : quarter_tab(k + 1);
        mag = lo + (((hi - lo) * fr) >>> FRAC_W);
        r   = TRIG_W'(mag);
        if (p[PHASE_W-1]) r = -r;
        return r;
    endfunction

    logic [LAT-1:0]        occ, tag, lst;
    logic [PHASE_W-1:0]    ph0;
    logic [2*TRIG_W-1:0]   word [LAT];

    // Control bits of every stage shift together on an advance.
    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
            tag <= '0;
            lst <= '0;
        end else if (adv) begin
            occ <= {occ[LAT-2:0], 1'b1};
            tag <= {tag[LAT-2:0], in_real};
            lst <= {lst[LAT-2:0], in_last};
        end
    end

    // Stage 0 holds the phase, stage 1 the looked-up pair.
    always_ff @(posedge clk) begin
        if (adv) begin
            ph0     <= in_phase;
            word[1] <= {sin_turn(ph0), sin_turn(ph0 + PHASE_W'(QTR))};
        end
    end

    assign word[0] = '0;

    generate
        for (genvar g = 2; g < LAT; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (adv) word[g] <= word[g-1];
            end
        end
    endgenerate

    assign out_fire = adv && occ[LAT-1];
    assign out_real = tag[LAT-1];
    assign out_last = lst[LAT-1];
    assign out_word = word[LAT-1];
endmodule

// File: rtl/pdw_drain_ctrl.sv
module pdw_drain_ctrl
    import pdw_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic s_valid,
    input  logic room,
    input  logic real_out,
    output logic s_ready,
    output logic adv,
    output logic push_real
);
    localparam int CW = $clog2(LAT + 1);

    drain_state_t    state, state_nxt;
    logic [CW-1:0]   cnt, cnt_nxt;
    logic            take_real, inject;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DR_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Outputs: accept a real word, or inject a filler while real ones are in flight.
    always_comb begin
        take_real = 1'b0;
        inject    = 1'b0;
        unique case (state)
            DR_IDLE: begin
                take_real = s_valid && room && !rst;
            end
            DR_FILL, DR_DRAIN: begin
                take_real = s_valid && room && !rst;
                inject    = !s_valid && room && !rst;
            end
            default: begin
                take_real = 1'b0;
            end
        endcase
        adv       = take_real || inject;
        push_real = take_real;
        s_ready   = room && !rst;
    end

    // Next state and in-flight count.
    always_comb begin
        cnt_nxt = cnt + CW'(take_real) - CW'(real_out);
        if (cnt_nxt == '0)
            state_nxt = DR_IDLE;
        else if (s_valid)
            state_nxt = DR_FILL;
        else
            state_nxt = DR_DRAIN;
    end

    // R2: a real result leaving the pipe must have been counted in.
    assert_no_phantom_R2: assert property (@(posedge clk) disable iff (rst)
        real_out |-> (cnt != '0));

    // R4: idle state means nothing real is left to drain.
    assert_idle_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (state == DR_IDLE) |-> (cnt == '0));
endmodule

// File: rtl/pdw_outbuf.sv
module pdw_outbuf #(
    parameter int W     = 33,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    output logic          room,
    output logic          m_valid,
    output logic [W-1:0]  m_data,
    input  logic          m_ready
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [PW-1:0]   wr, rd;
    logic [CNTW-1:0] cnt;
    logic            pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign pop     = m_valid && m_ready;
    assign m_valid = (cnt != '0);
    assign m_data  = mem[rd];
    assign room    = (cnt < CNTW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            wr  <= '0;
            rd  <= '0;
            cnt <= '0;
        end else begin
            if (push) wr <= bump(wr);
            if (pop)  rd <= bump(rd);
            cnt <= cnt + CNTW'(push) - CNTW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr] <= push_data;
    end

    // R8: a result is only written when a slot is free.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt < CNTW'(DEPTH)));

    // R6: a stalled result is held.
    assert_hold_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
endmodule

// File: rtl/phase_drain_wrap.sv
module phase_drain_wrap
    import pdw_pkg::*;
#(
    parameter int PHASE_W   = 24,
    parameter int LAT       = 4,
    parameter int BUF_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PHASE_W-1:0]   s_phase,
    input  logic                 s_last,
    input  logic                 s_valid,
    output logic                 s_ready,
    output logic [2*TRIG_W-1:0]  m_data,
    output logic                 m_last,
    output logic                 m_valid,
    input  logic                 m_ready
);
    localparam int BW = 2 * TRIG_W + 1;

    logic rst_q, rst_int;
    logic room, adv, push_real;
    logic out_fire, out_real, out_last;
    logic [2*TRIG_W-1:0] out_word;
    logic [BW-1:0] buf_data;

    // Widen reset to at least two cycles.
    always_ff @(posedge clk) rst_q <= rst;
    assign rst_int = rst | rst_q;

    pdw_drain_ctrl #(.LAT(LAT)) u_ctrl (
        .clk       (clk),
        .rst       (rst_int),
        .s_valid   (s_valid),
        .room      (room),
        .real_out  (out_fire && out_real),
        .s_ready   (s_ready),
        .adv       (adv),
        .push_real (push_real)
    );

    pdw_sincos_pipe #(.PHASE_W(PHASE_W), .LAT(LAT)) u_pipe (
        .clk      (clk),
        .rst      (rst_int),
        .adv      (adv),
        .in_phase (s_phase),
        .in_last  (s_last && push_real),
        .in_real  (push_real),
        .out_fire (out_fire),
        .out_real (out_real),
        .out_last (out_last),
        .out_word (out_word)
    );

    pdw_outbuf #(.W(BW), .DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .rst       (rst_int),
        .push      (out_fire && out_real),
        .push_data ({out_last, out_word}),
        .room      (room),
        .m_valid   (m_valid),
        .m_data    (buf_data),
        .m_ready   (m_ready)
    );

    assign m_last = buf_data[BW-1];
    assign m_data = buf_data[BW-2:0];

    // R7: input stays blocked for the cycle after reset falls.
    assert_rst_stretch_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !s_ready);
endmodule

// File: tb/phase_drain_wrap_test.sv
`timescale 1ns/1ps
module phase_drain_wrap_test;
    localparam int LAT = 4;
    localparam int BUF_DEPTH = 2;
    // phase, expected sine, expected cosine
    localparam int VEC [8][3] = '{
        '{32'h000000,      0,  16384},
        '{32'h200000,  11585,  11585},
        '{32'h400000,  16384,      0},
        '{32'h600000,  11585, -11585},
        '{32'h800000,      0, -16384},
        '{32'hA00000, -11585, -11585},
        '{32'hC00000, -16384,      0},
        '{32'hE00000, -11585,  11585}
    };

    logic clk = 0, rst = 1;
    logic [23:0] s_phase = '0;
    logic s_last = 0, s_valid = 0, s_ready;
    logic [31:0] m_data;
    logic m_last, m_valid, m_ready;

    int n_chk = 0, n_fail = 0, n_out = 0, n_last_in = 0, n_last_out = 0;
    int ready_mode = 0;
    bit done = 0;
    int q_sin[$], q_cos[$], q_tol[$];
    bit q_last[$];

    always #2.5 clk = ~clk;

    phase_drain_wrap uut (
        .clk(clk), .rst(rst), .s_phase(s_phase), .s_last(s_last),
        .s_valid(s_valid), .s_ready(s_ready), .m_data(m_data),
        .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_val(input int ph, input bit is_cos);
        real a, r;
        a = 6.283185307179586 * real'(ph) / 16777216.0;
        r = is_cos ? $cos(a) : $sin(a);
        return int'(r * 16384.0);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Output side: choose ready, then score any transfer at the coming edge.
    always @(negedge clk) begin
        case (ready_mode)
            1: m_ready = ($urandom % 2) == 0;
            2: m_ready = 1'b0;
            default: m_ready = 1'b1;
        endcase
        if (!rst && m_valid && m_ready) begin
            n_out++;
            if (m_last) n_last_out++;
            if (q_sin.size() == 0) begin
                chk(0, "R5", "output with nothing expected", 1, 0);
            end else begin
                int es, ec, tl, as, ac;
                bit el;
                es = q_sin.pop_front(); ec = q_cos.pop_front();
                tl = q_tol.pop_front(); el = q_last.pop_front();
                as = int'($signed(m_data[31:16]));
                ac = int'($signed(m_data[15:0]));
                chk(iabs(as - es) <= tl, "R1", "sine value", as, es);
                chk(iabs(ac - ec) <= tl, "R2", "cosine value in order", ac, ec);
                chk(m_last == el, "R3", "last flag", int'(m_last), int'(el));
            end
        end
    end

    task automatic send(input int ph, input bit lst, input int es, input int ec, input int tol);
        @(negedge clk);
        s_valid = 1'b1;
        s_phase = 24'(ph);
        s_last  = lst;
        while (!s_ready) @(negedge clk);
        q_sin.push_back(es); q_cos.push_back(ec);
        q_tol.push_back(tol); q_last.push_back(lst);
        if (lst) n_last_in++;
    endtask

    task automatic send_rand(input bit lst);
        int ph;
        ph = int'($urandom() & 32'h00FF_FFFF);
        send(ph, lst, ref_val(ph, 0), ref_val(ph, 1), 8);
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
        for (int k = 1; k < n; k++) @(negedge clk);
    endtask

    task automatic drain_wait(input string req);
        for (int k = 0; k < 300 && q_sin.size() != 0; k++) @(negedge clk);
        chk(q_sin.size() == 0, req, "results left pending", q_sin.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R4 watchdog expired: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // Reset behaviour (R7)
        repeat (3) @(negedge clk);
        chk(s_ready == 1'b0, "R7", "s_ready in reset", int'(s_ready), 0);
        chk(m_valid == 1'b0, "R7", "m_valid in reset", int'(m_valid), 0);
        rst = 1'b0;
        #1;
        chk(s_ready == 1'b0, "R7", "s_ready one cycle after reset", int'(s_ready), 0);
        @(negedge clk);
        chk(s_ready == 1'b1, "R7", "s_ready after stretch", int'(s_ready), 1);

        // Table walk at eighth-turn points (R1, R2, R3)
        for (int i = 0; i < 8; i++) send(VEC[i][0], i == 7, VEC[i][1], VEC[i][2], 0);
        go_idle(1);
        drain_wait("R4");
        chk(n_last_out == n_last_in, "R3", "last flags out", n_last_out, n_last_in);

        // Single phase then silence (R4)
        begin
            int start, k;
            start = n_out;
            send_rand(1'b1);
            k = 0;
            while (n_out == start && k < 20) begin
                @(negedge clk);
                if (k == 0) begin s_valid = 1'b0; s_last = 1'b0; end
                k++;
            end
            chk(k <= LAT + 4, "R4", "cycles to drain one phase", k, LAT + 4);
        end
        drain_wait("R4");

        // Stalled output, continuous input (R8, R6)
        ready_mode = 2;
        begin
            int acc;
            logic [31:0] held;
            acc = 0;
            for (int i = 0; i < 20; i++) begin
                int ph;
                @(negedge clk);
                ph = int'($urandom() & 32'h00FF_FFFF);
                s_valid = 1'b1; s_phase = 24'(ph); s_last = (i == 19);
                if (s_ready) begin
                    acc++;
                    q_sin.push_back(ref_val(ph, 0)); q_cos.push_back(ref_val(ph, 1));
                    q_tol.push_back(8); q_last.push_back(1'b0);
                end
            end
            go_idle(1);
            chk(acc == BUF_DEPTH + LAT, "R8", "phases accepted while stalled", acc, BUF_DEPTH + LAT);
            held = m_data;
            repeat (3) @(negedge clk);
            chk(m_valid == 1'b1, "R6", "m_valid held", int'(m_valid), 1);
            chk(m_data == held, "R6", "m_data held", int'(m_data), int'(held));
        end
        ready_mode = 0;
        drain_wait("R8");

        // Random traffic with gaps and random last flags (R2, R3, R4, R5)
        ready_mode = 1;
        for (int i = 0; i < 150; i++) begin
            send_rand(($urandom % 8) == 0);
            if (($urandom % 3) == 0) go_idle(1 + ($urandom % 6));
        end
        go_idle(30);
        ready_mode = 0;
        drain_wait("R4");
        repeat (10) @(negedge clk);
        chk(m_valid == 1'b0, "R5", "no output after drain", int'(m_valid), 0);
        chk(n_last_out == n_last_in, "R3", "last flags out", n_last_out, n_last_in);

        // One-cycle reset pulse is stretched (R7)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(s_ready == 1'b0, "R7", "s_ready after one-cycle pulse", int'(s_ready), 0);
        @(negedge clk);
        chk(s_ready == 1'b1, "R7", "s_ready after pulse stretch", int'(s_ready), 1);
        chk(m_valid == 1'b0, "R7", "m_valid after pulse", int'(m_valid), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule